// File: doc/BRIEF.md
# Display Power Sequencer

This block brings a small monochrome display panel up and takes it down again in a safe order. It drives the enable for the panel's logic supply and the enable for its high-voltage drive rail. It holds the panel in reset for a fixed minimum time after the logic supply comes on. It also sends command and pixel bytes over a serial link that has an active-low chip select, a serial clock, a data line and a command/data select line.

A one-cycle power-up request starts a fixed sequence. First the logic supply comes on and the panel reset is released. The block then sends the display-off command, the initialisation command list, and enough zero bytes to blank the whole pixel area. After that it enables the high-voltage rail, waits a settle interval, and sends display-on. A power-down request runs the reverse sequence: display-off, high voltage off, a settle interval for discharge, then logic supply off.

A power-down request can arrive while power-up is still running. In that case the byte on the wire is allowed to finish and the block then switches to the power-down path. Both delays are derived from the clock frequency parameter, so each one is an exact number of cycles.

Top module: `disp_power_seq`

## Requirements
- R1: While rst_n is low, and after it is released, vdd_en, vcc_en, panel_rst_n, spi_sclk, busy and ready are 0 and spi_cs_n is 1.
- R2: After vdd_en rises, panel_rst_n stays low for at least RST_CYC = ceil(CLK_HZ·RESET_US/10^6) cycles. It is high before the first chip-select assertion, and no byte is ever sent while panel_rst_n is low.
- R3: A power-up sends these bytes in order: 0xAE (display off), the INIT_LEN bytes of INIT_SEQ with the most significant byte first, COLS·ROWS/8 bytes of 0x00, and 0xAF (display on).
- R4: dc_sel is 0 for every command byte (0xAE, 0xAF and the init list) and 1 for every clear byte. It does not change while spi_cs_n is low.
- R5: Each byte is framed by spi_cs_n low and carries 8 rising spi_sclk edges, MSB first. Data is stable at each rising edge, spi_sclk is low whenever spi_cs_n is high, and spi_cs_n stays high for at least one cycle between bytes.
- R6: vcc_en rises only after the last clear byte has finished. The display-on byte starts at least SETTLE_CYC = CLK_HZ·SETTLE_MS/1000 cycles after vcc_en rises, and no more than 4 cycles later than that. vcc_en is never high while vdd_en is low.
- R7: A power-down request in the ready state sends 0xAE. vcc_en then falls after that byte ends. vdd_en falls at least SETTLE_CYC cycles after vcc_en falls, and panel_rst_n returns low together with vdd_en.
- R8: A power-down request during power-up lets any byte already started finish. The next and only further byte is 0xAE, after which the power-down path of R7 follows and ends with both enables low.
- R9: busy is high from the cycle after an accepted request until the sequence completes. ready is high only after 0xAF has been sent, and never together with busy.
- R10: A power-up request while ready, and a power-down request while off, have no effect: no byte is sent and no output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_up_req | input | 1 | Request to power the panel up (sampled while off) |
| pwr_dn_req | input | 1 | Request to power the panel down |
| vdd_en | output | 1 | Enable for the panel logic supply |
| vcc_en | output | 1 | Enable for the panel high-voltage rail |
| panel_rst_n | output | 1 | Active-low reset to the panel |
| spi_cs_n | output | 1 | Active-low chip select of the serial link |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, MSB first |
| dc_sel | output | 1 | 0 = command byte, 1 = display data byte |
| busy | output | 1 | A power sequence is in progress |
| ready | output | 1 | Panel is powered and displaying |

## Verification
The bench builds the block with CLK_HZ = 10000, SETTLE_MS = 100 and RESET_US = 500, which gives a 1000-cycle settle interval and a 5-cycle reset pulse. It uses a one-cycle serial half period and a 16×8 area, so a clear takes 16 bytes. With these values a full power-up takes about 1400 cycles. That makes it possible to sweep the power-down request across the whole power-up sequence in steps of 47 cycles. The sweep lands the abort in the reset pulse, inside every byte class and inside the settle wait, and each landing is checked for the in-flight-byte rule and for the final supply order.

// File: rtl/dps_pkg.sv
// Shared constants and state type for the display power sequencer.
// Assumes a panel whose display-off and display-on commands are single bytes.
package dps_pkg;

    localparam logic [7:0] CMD_PANEL_OFF = 8'hAE;
    localparam logic [7:0] CMD_PANEL_ON  = 8'hAF;

    typedef enum logic [3:0] {
        PS_OFF,        // both rails off, panel held in reset
        PS_RST,        // logic rail on, reset pulse timing
        PS_UP_OFF,     // sending display-off during power-up
        PS_INIT,       // sending the init command list
        PS_CLEAR,      // sending zero data over the pixel area
        PS_HV_SETTLE,  // high voltage on, waiting for it to settle
        PS_UP_ON,      // sending display-on
        PS_ON,         // panel running
        PS_DN_OFF,     // sending display-off during power-down
        PS_DN_SETTLE   // high voltage off, waiting for discharge
    } pwr_state_t;

endpackage

// File: rtl/dps_settle_timer.sv
// Loadable down-counter used for both the reset pulse and the rail settle waits.
// Assumes load_val is at least 1; expired is high while the count is zero.
module dps_settle_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    // Count down from the loaded value and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_TIMER_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired); // R6

endmodule

// File: rtl/dps_byte_tx.sv
// Serial byte sender: one byte per start pulse, MSB first, clock idle low,
// data changed while the clock is low. The command/data select is latched
// with the byte and held for the whole frame. Start is honoured only when idle.
module dps_byte_tx #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    input  logic       dc_in,
    output logic       done,
    output logic       cs_n,
    output logic       sclk,
    output logic       mosi,
    output logic       dc
);

    localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);

    logic          active;
    logic [7:0]    shreg;
    logic [2:0]    bit_idx;
    logic [HW-1:0] half_cnt;

    // Frame sequencing: load on start, toggle the clock every half period,
    // advance a bit after each high phase, close the frame after bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            shreg    <= '0;
            bit_idx  <= '0;
            half_cnt <= '0;
            done     <= 1'b0;
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            mosi     <= 1'b0;
            dc       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    cs_n     <= 1'b0;
                    shreg    <= byte_in;
                    mosi     <= byte_in[7];
                    dc       <= dc_in;
                    bit_idx  <= '0;
                    half_cnt <= '0;
                    sclk     <= 1'b0;
                end
            end else if (half_cnt == HALF_LAST) begin
                half_cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        active <= 1'b0;
                        cs_n   <= 1'b1;
                        done   <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[6:0], 1'b0};
                        mosi    <= shreg[6];
                    end
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    AST_DC_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(dc)); // R4
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R5
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R5

endmodule

// File: rtl/dps_seq_ctrl.sv
// Power sequencing state machine. Drives the supply enables and panel reset,
// chooses the next byte for the serial sender and loads the shared timer.
// Assumes one sender in flight at a time: it starts a byte only after the
// previous one reported done. A power-down request seen during power-up is
// remembered and acted on at the next byte boundary or wait.
module dps_seq_ctrl
    import dps_pkg::*;
#(
    parameter int unsigned          INIT_LEN    = 4,
    parameter logic [INIT_LEN*8-1:0] INIT_SEQ   = 32'hA1A48180,
    parameter int unsigned          CLEAR_BYTES = 1280,
    parameter int unsigned          RST_CYC     = 150,
    parameter int unsigned          SETTLE_CYC  = 5000000,
    parameter int unsigned          TW          = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_req,
    input  logic          dn_req,
    input  logic          tx_done,
    input  logic          tmr_expired,
    output logic          tx_start,
    output logic [7:0]    tx_byte,
    output logic          tx_dc,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          vdd_en,
    output logic          vcc_en,
    output logic          panel_rst_n,
    output logic          busy,
    output logic          ready
);

    localparam int unsigned MAXN = (INIT_LEN > CLEAR_BYTES) ? INIT_LEN : CLEAR_BYTES;
    localparam int unsigned IW   = (MAXN > 1) ? $clog2(MAXN) : 1;
    localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_LEN - 1);
    localparam logic [IW-1:0] CLEAR_LAST = IW'(CLEAR_BYTES - 1);

    pwr_state_t    st, st_nx;
    logic          issued, issued_nx;
    logic [IW-1:0] idx, idx_nx;
    logic          dn_pend, dn_pend_nx;
    logic          vdd_nx, vcc_nx, prst_nx;
    logic          sending, up_phase, dn_any;
    logic [7:0]    init_byte;

    // Select the current entry of the init list.
    always_comb begin
        init_byte = '0;
        for (int i = 0; i < INIT_LEN; i++) begin
            if (idx == IW'(i)) init_byte = INIT_SEQ[(INIT_LEN-1-i)*8 +: 8];
        end
    end

    // Classify the state and request the next byte when none is in flight.
    always_comb begin
        sending  = (st == PS_UP_OFF) || (st == PS_INIT) || (st == PS_CLEAR) ||
                   (st == PS_UP_ON)  || (st == PS_DN_OFF);
        up_phase = (st == PS_RST) || (st == PS_UP_OFF) || (st == PS_INIT) ||
                   (st == PS_CLEAR) || (st == PS_HV_SETTLE) || (st == PS_UP_ON);
        dn_any   = dn_pend || dn_req;
        tx_start = sending && !issued;
        tx_dc    = (st == PS_CLEAR);
        case (st)
            PS_INIT:  tx_byte = init_byte;
            PS_CLEAR: tx_byte = 8'h00;
            PS_UP_ON: tx_byte = CMD_PANEL_ON;
            default:  tx_byte = CMD_PANEL_OFF;
        endcase
    end

    // Next-state, rail, reset and timer-load decisions.
    always_comb begin
        st_nx      = st;
        issued_nx  = issued | tx_start;
        idx_nx     = idx;
        dn_pend_nx = dn_pend | (dn_req & up_phase);
        vdd_nx     = vdd_en;
        vcc_nx     = vcc_en;
        prst_nx    = panel_rst_n;
        tmr_load   = 1'b0;
        tmr_val    = TW'(SETTLE_CYC);
        case (st)
            PS_OFF: begin
                if (up_req) begin
                    vdd_nx   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_CYC);
                    st_nx    = PS_RST;
                end
            end
            PS_RST: begin
                if (tmr_expired) begin
                    prst_nx   = 1'b1;
                    issued_nx = 1'b0;
                    st_nx     = dn_any ? PS_DN_OFF : PS_UP_OFF;
                end
            end
            PS_UP_OFF: begin
                if (tx_done) begin
                    issued_nx = 1'b0;
                    idx_nx    = '0;
                    st_nx     = dn_any ? PS_DN_OFF : PS_INIT;
                end
            end
            PS_INIT: begin
                if (tx_done) begin
                    issued_nx = 1'b0;
                    if (dn_any) begin
                        st_nx = PS_DN_OFF;
                    end else if (idx == INIT_LAST) begin
                        idx_nx = '0;
                        st_nx  = PS_CLEAR;
                    end else begin
                        idx_nx = idx + 1'b1;
                    end
                end
            end
            PS_CLEAR: begin
                if (tx_done) begin
                    issued_nx = 1'b0;
                    if (dn_any) begin
                        st_nx = PS_DN_OFF;
                    end else if (idx == CLEAR_LAST) begin
                        vcc_nx   = 1'b1;
                        tmr_load = 1'b1;
                        st_nx    = PS_HV_SETTLE;
                    end else begin
                        idx_nx = idx + 1'b1;
                    end
                end
            end
            PS_HV_SETTLE: begin
                if (dn_any) begin
                    issued_nx = 1'b0;
                    st_nx     = PS_DN_OFF;
                end else if (tmr_expired) begin
                    issued_nx = 1'b0;
                    st_nx     = PS_UP_ON;
                end
            end
            PS_UP_ON: begin
                if (tx_done) begin
                    issued_nx = 1'b0;
                    st_nx     = dn_any ? PS_DN_OFF : PS_ON;
                end
            end
            PS_ON: begin
                if (dn_req) begin
                    issued_nx = 1'b0;
                    st_nx     = PS_DN_OFF;
                end
            end
            PS_DN_OFF: begin
                if (tx_done) begin
                    issued_nx = 1'b0;
                    vcc_nx    = 1'b0;
                    tmr_load  = 1'b1;
                    st_nx     = PS_DN_SETTLE;
                end
            end
            PS_DN_SETTLE: begin
                if (tmr_expired) begin
                    vdd_nx  = 1'b0;
                    prst_nx = 1'b0;
                    st_nx   = PS_OFF;
                end
            end
            default: st_nx = PS_OFF;
        endcase
        if ((st_nx == PS_DN_OFF) || (st_nx == PS_DN_SETTLE) || (st_nx == PS_OFF)) begin
            dn_pend_nx = 1'b0;
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= PS_OFF;
            issued      <= 1'b0;
            idx         <= '0;
            dn_pend     <= 1'b0;
            vdd_en      <= 1'b0;
            vcc_en      <= 1'b0;
            panel_rst_n <= 1'b0;
        end else begin
            st          <= st_nx;
            issued      <= issued_nx;
            idx         <= idx_nx;
            dn_pend     <= dn_pend_nx;
            vdd_en      <= vdd_nx;
            vcc_en      <= vcc_nx;
            panel_rst_n <= prst_nx;
        end
    end

    assign busy  = (st != PS_OFF) && (st != PS_ON);
    assign ready = (st == PS_ON);

    AST_HV_NEEDS_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_en |-> vdd_en); // R6
    AST_HV_RISE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> ($past(st) == PS_CLEAR) && $past(tx_done)); // R6
    AST_HV_FALL_AFTER_OFF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> ($past(st) == PS_DN_OFF) && $past(tx_done)); // R7
    AST_LOGIC_FALL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vdd_en) |-> !vcc_en && !panel_rst_n); // R7
    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !busy && vcc_en); // R9

endmodule

// File: rtl/disp_power_seq.sv
// Top of the display power sequencer. Derives the reset and settle cycle
// counts from the clock frequency and ties together the sequencing FSM,
// the shared delay timer and the serial byte sender.
// Assumes CLK_HZ·RESET_US and CLK_HZ·SETTLE_MS fit in 64 bits.
module disp_power_seq #(
    parameter int unsigned          CLK_HZ    = 50000000,
    parameter int unsigned          SETTLE_MS = 100,
    parameter int unsigned          RESET_US  = 3,
    parameter int unsigned          SCLK_HALF = 4,
    parameter int unsigned          COLS      = 128,
    parameter int unsigned          ROWS      = 80,
    parameter int unsigned          INIT_LEN  = 4,
    parameter logic [INIT_LEN*8-1:0] INIT_SEQ = 32'hA1A48180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up_req,
    input  logic pwr_dn_req,
    output logic vdd_en,
    output logic vcc_en,
    output logic panel_rst_n,
    output logic spi_cs_n,
    output logic spi_sclk,
    output logic spi_mosi,
    output logic dc_sel,
    output logic busy,
    output logic ready
);

    localparam logic [63:0] SETTLE_RAW = (64'(CLK_HZ) * 64'(SETTLE_MS)) / 64'd1000;
    localparam logic [63:0] RST_RAW    = (64'(CLK_HZ) * 64'(RESET_US) + 64'd999999) / 64'd1000000;
    localparam int unsigned SETTLE_CYC = (SETTLE_RAW < 64'd1) ? 1 : int'(SETTLE_RAW);
    localparam int unsigned RST_CYC    = (RST_RAW < 64'd1) ? 1 : int'(RST_RAW);
    localparam int unsigned MAX_DLY    = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
    localparam int unsigned TW         = $clog2(MAX_DLY + 1);
    localparam int unsigned CLEAR_BYTES = (COLS * ROWS + 7) / 8;

    logic          tx_start, tx_done, tx_dc;
    logic [7:0]    tx_byte;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;

    dps_seq_ctrl #(
        .INIT_LEN    (INIT_LEN),
        .INIT_SEQ    (INIT_SEQ),
        .CLEAR_BYTES (CLEAR_BYTES),
        .RST_CYC     (RST_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .TW          (TW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_req      (pwr_up_req),
        .dn_req      (pwr_dn_req),
        .tx_done     (tx_done),
        .tmr_expired (tmr_expired),
        .tx_start    (tx_start),
        .tx_byte     (tx_byte),
        .tx_dc       (tx_dc),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .vdd_en      (vdd_en),
        .vcc_en      (vcc_en),
        .panel_rst_n (panel_rst_n),
        .busy        (busy),
        .ready       (ready)
    );

    dps_settle_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dps_byte_tx #(
        .HALF_CYC (SCLK_HALF)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .byte_in (tx_byte),
        .dc_in   (tx_dc),
        .done    (tx_done),
        .cs_n    (spi_cs_n),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .dc      (dc_sel)
    );

    AST_NO_BYTE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> (panel_rst_n && vdd_en)); // R2
    AST_NO_BYTE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> spi_cs_n); // R9

endmodule

// File: tb/disp_power_seq_tb_top.sv
module disp_power_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE_N   = 1000;   // 10000 Hz * 100 ms
    localparam int RST_N      = 5;      // ceil(10000 Hz * 500 us)
    localparam int INIT_N     = 4;
    localparam logic [31:0] INIT_V = 32'hA1A48180;
    localparam int CLEAR_N    = 16;     // 16 x 8 / 8
    localparam int UP_BYTES   = 1 + INIT_N + CLEAR_N + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_up_req = 1'b0;
    logic pwr_dn_req = 1'b0;
    logic vdd_en, vcc_en, panel_rst_n, spi_cs_n, spi_sclk, spi_mosi, dc_sel, busy, ready;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_power_seq #(
        .CLK_HZ    (10000),
        .SETTLE_MS (100),
        .RESET_US  (500),
        .SCLK_HALF (1),
        .COLS      (16),
        .ROWS      (8),
        .INIT_LEN  (INIT_N),
        .INIT_SEQ  (INIT_V)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .pwr_up_req (pwr_up_req), .pwr_dn_req (pwr_dn_req),
        .vdd_en (vdd_en), .vcc_en (vcc_en), .panel_rst_n (panel_rst_n),
        .spi_cs_n (spi_cs_n), .spi_sclk (spi_sclk), .spi_mosi (spi_mosi),
        .dc_sel (dc_sel), .busy (busy), .ready (ready)
    );

    // expected power-up byte stream
    logic [7:0] exp_b  [UP_BYTES];
    logic       exp_dc [UP_BYTES];
    initial begin
        exp_b[0] = 8'hAE; exp_dc[0] = 1'b0;
        for (int i = 0; i < INIT_N; i++) begin
            exp_b[1+i] = INIT_V[(INIT_N-1-i)*8 +: 8]; exp_dc[1+i] = 1'b0;
        end
        for (int i = 0; i < CLEAR_N; i++) begin
            exp_b[1+INIT_N+i] = 8'h00; exp_dc[1+INIT_N+i] = 1'b1;
        end
        exp_b[UP_BYTES-1] = 8'hAF; exp_dc[UP_BYTES-1] = 1'b0;
    end

    // serial receiver model
    logic [7:0] lg_b   [64];
    logic       lg_dc  [64];
    logic       lg_vcc [64];
    time        lg_ts  [64];
    time        lg_te  [64];
    int   n_rx = 0;
    int   rx_bits = 0;
    logic [7:0] rx_sh = '0;
    logic rx_dc = 1'b0;
    time  rx_t0 = 0;
    time  t_cs_rise = 0;
    int   frame_err = 0;
    int   dc_err = 0;
    time  t_vdd_r = 0, t_vdd_f = 0, t_vcc_r = 0, t_vcc_f = 0, t_prst_r = 0;

    always @(negedge spi_cs_n) begin
        rx_bits = 0; rx_sh = '0; rx_dc = dc_sel; rx_t0 = $time;
        if ($time - t_cs_rise < CLK_PERIOD) frame_err++;
    end
    always @(posedge spi_sclk) begin
        if (spi_cs_n) frame_err++;
        else begin
            if (dc_sel !== rx_dc) dc_err++;
            rx_sh = {rx_sh[6:0], spi_mosi};
            rx_bits++;
        end
    end
    always @(posedge spi_cs_n) begin
        t_cs_rise = $time;
        if (rx_bits != 0) begin
            if (rx_bits != 8) frame_err++;
            if (n_rx < 64) begin
                lg_b[n_rx] = rx_sh; lg_dc[n_rx] = rx_dc; lg_vcc[n_rx] = vcc_en;
                lg_ts[n_rx] = rx_t0; lg_te[n_rx] = $time;
            end
            n_rx++;
            rx_bits = 0;
        end
    end
    always @(posedge vdd_en) t_vdd_r = $time;
    always @(negedge vdd_en) t_vdd_f = $time;
    always @(posedge vcc_en) t_vcc_r = $time;
    always @(negedge vcc_en) t_vcc_f = $time;
    always @(posedge panel_rst_n) t_prst_r = $time;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic pulse_up();
        @(negedge clk) pwr_up_req = 1'b1;
        @(negedge clk) pwr_up_req = 1'b0;
    endtask

    task automatic pulse_dn(output time t_seen);
        @(negedge clk) pwr_dn_req = 1'b1;
        t_seen = $time + CLK_PERIOD/2;
        @(negedge clk) pwr_dn_req = 1'b0;
    endtask

    task automatic wait_idle(input int lim, output bit ok);
        ok = 1'b0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (!busy) begin ok = 1'b1; break; end
        end
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit  ok;
        time t_dn;
        time run_t0;
        int  after, nb;
        bit  pre_ok;

        repeat (4) @(negedge clk);
        // R1 reset state, during and after reset
        chk(!vdd_en && !vcc_en && !panel_rst_n && spi_cs_n && !spi_sclk && !busy && !ready,
            "R1 in reset", {vdd_en, vcc_en, panel_rst_n, spi_cs_n, busy, ready}, 6'b000100);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!vdd_en && !vcc_en && !panel_rst_n && spi_cs_n && !busy && !ready,
            "R1 after reset", {vdd_en, vcc_en, panel_rst_n, spi_cs_n, busy, ready}, 6'b000100);

        // R10 power-down request while off
        pulse_dn(t_dn);
        repeat (50) @(negedge clk);
        chk(!vdd_en && !busy && n_rx == 0, "R10 dn while off", n_rx, 0);

        // full power-up
        n_rx = 0;
        pulse_up();
        chk(busy && vdd_en, "R9 busy after up request", busy, 1);
        wait_idle(5000, ok);
        chk(ok && ready, "R9 ready after power-up", ready, 1);
        chk(n_rx == UP_BYTES, "R3 byte count", n_rx, UP_BYTES);
        for (int i = 0; i < UP_BYTES; i++) begin
            chk(lg_b[i] == exp_b[i], "R3 byte value", lg_b[i], exp_b[i]);
            chk(lg_dc[i] == exp_dc[i], "R4 dc select", lg_dc[i], exp_dc[i]);
        end
        chk((t_prst_r - t_vdd_r) / CLK_PERIOD >= RST_N, "R2 reset pulse length",
            (t_prst_r - t_vdd_r) / CLK_PERIOD, RST_N);
        chk(lg_ts[0] > t_prst_r, "R2 first byte after reset", lg_ts[0], t_prst_r);
        chk(t_vcc_r >= lg_te[UP_BYTES-2] && lg_vcc[UP_BYTES-2] == 1'b0,
            "R6 hv after clear", t_vcc_r, lg_te[UP_BYTES-2]);
        chk((lg_ts[UP_BYTES-1] - t_vcc_r) / CLK_PERIOD >= SETTLE_N &&
            (lg_ts[UP_BYTES-1] - t_vcc_r) / CLK_PERIOD <= SETTLE_N + 4,
            "R6 settle before display-on", (lg_ts[UP_BYTES-1] - t_vcc_r) / CLK_PERIOD, SETTLE_N);
        chk(frame_err == 0, "R5 framing", frame_err, 0);
        chk(dc_err == 0, "R4 dc stable in frame", dc_err, 0);
        chk(!busy && vcc_en && vdd_en && panel_rst_n, "R9 ready not busy", busy, 0);

        // R10 power-up request while ready
        n_rx = 0;
        pulse_up();
        repeat (100) @(negedge clk);
        chk(n_rx == 0 && ready && !busy && vcc_en, "R10 up while ready", n_rx, 0);

        // R7 normal power-down
        pulse_dn(t_dn);
        chk(busy && !ready, "R9 busy during power-down", busy, 1);
        wait_idle(5000, ok);
        chk(ok && n_rx == 1 && lg_b[0] == 8'hAE && lg_dc[0] == 1'b0, "R7 display-off sent",
            lg_b[0], 8'hAE);
        chk(t_vcc_f >= lg_te[0], "R7 hv drops after display-off", t_vcc_f, lg_te[0]);
        chk((t_vdd_f - t_vcc_f) / CLK_PERIOD >= SETTLE_N, "R7 discharge wait",
            (t_vdd_f - t_vcc_f) / CLK_PERIOD, SETTLE_N);
        chk(!vdd_en && !vcc_en && !panel_rst_n && !ready, "R7 final rails",
            {vdd_en, vcc_en, panel_rst_n}, 0);

        // R8 abort sweep across the whole power-up sequence
        for (int off = 1; off < 1300; off += 47) begin
            n_rx = 0;
            run_t0 = $time;
            pulse_up();
            repeat (off) @(negedge clk);
            pulse_dn(t_dn);
            wait_idle(5000, ok);
            nb = (n_rx < 64) ? n_rx : 64;
            chk(ok && !vdd_en && !vcc_en && !panel_rst_n && !ready, "R8 abort final rails",
                {vdd_en, vcc_en}, 0);
            chk(nb >= 1 && lg_b[nb-1] == 8'hAE && lg_dc[nb-1] == 1'b0, "R8 abort ends with off",
                (nb >= 1) ? lg_b[nb-1] : 0, 8'hAE);
            after = 0;
            for (int i = 0; i < nb; i++) if (lg_ts[i] > t_dn) after++;
            chk(after == 1, "R8 only display-off after request", after, 1);
            pre_ok = 1'b1;
            for (int i = 0; i < nb - 1; i++) begin
                if (i >= UP_BYTES || lg_b[i] != exp_b[i] || lg_dc[i] != exp_dc[i]) pre_ok = 1'b0;
            end
            chk(pre_ok, "R8 in-flight prefix matches power-up order", off, 0);
            chk(nb >= 1 && (t_vdd_f - lg_te[nb-1]) / CLK_PERIOD >= SETTLE_N &&
                (t_vcc_r < run_t0 || t_vcc_f >= lg_te[nb-1]),
                "R8 rails drop after display-off", (t_vdd_f - lg_te[nb-1]) / CLK_PERIOD, SETTLE_N);
        end
        chk(frame_err == 0 && dc_err == 0, "R5 framing over sweep", frame_err + dc_err, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule